// File: doc/BRIEF.md
# Reversible Gate Library with Inverses

This block evaluates one of four reversible logic gates on a four-lane input vector. The four gates are a two-lane controlled-XOR gate, a three-lane controlled-swap gate, a four-lane adder-capable gate (called TSG here) and a four-lane Sayem-style gate. Every gate has the same number of outputs as inputs, and each gate is a one-to-one mapping. A gate-select input picks the gate. A direction bit picks either the forward function or its exact inverse, so a vector passed forward and then backward through the same gate comes back unchanged.

Lane 0 always carries the control operand A. Lanes 1, 2 and 3 carry B, C and D in that order. A gate that uses fewer than four lanes passes its unused lanes through unchanged. The block also reports a small quantum-cost figure for the selected gate. It flags a select code that names no gate. The block is purely combinational, with no clock and no storage.

Top module: `rev_gate_lib`

## Requirements
- R1: Select code 0 with forward direction gives out0=A and out1=A XOR B, and passes lanes 2 and 3 unchanged.
- R2: Select code 1 with forward direction keeps lane 0 and lane 3. When A=1 it exchanges lanes 1 and 2. When A=0 it leaves lanes 1 and 2 as they are.
- R3: Select code 2 with forward direction gives out0=A and Q=(NOT A AND NOT C) XOR NOT B on lane 1. It gives R=Q XOR D on lane 2 and S=(Q AND D) XOR (A AND B) XOR C on lane 3.
- R4: Select code 3 with forward direction gives out0=A, out1=(A ? C : B), out2=out1 XOR D and out3=(A ? B : C) XOR D.
- R5: With direction bit 1 (backward), codes 0 and 1 apply the same mapping as forward, because those gates are their own inverses.
- R6: Backward evaluation of code 2 returns the original vector for every one of the 16 forward results. Lane 3 of the backward result equals lane 1 XOR lane 2 of its input.
- R7: Backward evaluation of code 3 returns the original vector for every one of the 16 forward results. Lane 3 of the backward result equals lane 1 XOR lane 2 of its input.
- R8: For each valid code, the forward mapping produces 16 distinct output vectors over the 16 input vectors.
- R9: Forward evaluation of the backward result returns the original vector for every valid code and every input vector.
- R10: The cost output reads 1 for code 0 and 5 for code 1. It reads 0 for codes 2 and 3, whose cost is not characterised.
- R11: Codes 4 to 7 drive the data and cost outputs to zero and raise the invalid flag in both directions. The flag is low for codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gate_sel | input | SEL_W (3) | Gate choice: 0 controlled-XOR, 1 controlled-swap, 2 TSG, 3 Sayem-style, 4-7 invalid |
| dir_bwd | input | 1 | 0 = forward function, 1 = inverse function |
| din | input | 4 | Input lanes, bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D |
| dout | output | 4 | Output lanes, same bit order as din |
| qcost | output | COST_W (4) | Quantum cost of the selected gate |
| sel_bad | output | 1 | High when gate_sel names no gate |

## Verification
All results are due in the same cycle as the stimulus, because no register lies between any input and any output. The bench changes the inputs on a falling clock edge. It reads the outputs on the next rising edge, after the logic has settled, and it never reads on the edge where the inputs change. Each round-trip check applies the forward vector first and holds it for one cycle. It then feeds the captured result back with the direction bit flipped and reads it one cycle later.

// File: rtl/rev_pkg.sv
package rev_pkg;

    localparam int LANES   = 4;
    localparam int NGATES  = 4;
    localparam int GIDX_W  = $clog2(NGATES);
    localparam int COST_W0 = 4;

    typedef enum logic [GIDX_W-1:0] {
        G_CXOR  = 2'd0,
        G_CSWAP = 2'd1,
        G_TSG   = 2'd2,
        G_SAYEM = 2'd3
    } gate_e;

    typedef struct packed {
        logic l3;
        logic l2;
        logic l1;
        logic l0;
    } quad_t;

    // controlled XOR: lane1 ^= lane0
    function automatic quad_t cxor_map(input quad_t v);
        quad_t r;
        r    = v;
        r.l1 = v.l0 ^ v.l1;
        return r;
    endfunction

    // controlled swap of lanes 1 and 2 under lane 0
    function automatic quad_t cswap_map(input quad_t v);
        quad_t r;
        r    = v;
        r.l1 = v.l0 ? v.l2 : v.l1;
        r.l2 = v.l0 ? v.l1 : v.l2;
        return r;
    endfunction

    function automatic quad_t tsg_fwd(input quad_t v);
        quad_t r;
        logic  q;
        q    = (~v.l0 & ~v.l2) ^ ~v.l1;
        r.l0 = v.l0;
        r.l1 = q;
        r.l2 = q ^ v.l3;
        r.l3 = (q & v.l3) ^ (v.l0 & v.l1) ^ v.l2;
        return r;
    endfunction

    function automatic quad_t tsg_bwd(input quad_t v);
        quad_t r;
        logic  dd, bb, cc;
        dd = v.l1 ^ v.l2;
        if (v.l0) begin
            bb = ~v.l1;
            cc = v.l3 ^ (v.l1 & dd) ^ bb;
        end else begin
            cc = v.l3 ^ (v.l1 & dd);
            bb = v.l1 ^ cc;
        end
        r.l0 = v.l0;
        r.l1 = bb;
        r.l2 = cc;
        r.l3 = dd;
        return r;
    endfunction

    function automatic quad_t sayem_fwd(input quad_t v);
        quad_t r;
        logic  m1, m2;
        m1   = v.l0 ? v.l2 : v.l1;
        m2   = v.l0 ? v.l1 : v.l2;
        r.l0 = v.l0;
        r.l1 = m1;
        r.l2 = m1 ^ v.l3;
        r.l3 = m2 ^ v.l3;
        return r;
    endfunction

    function automatic quad_t sayem_bwd(input quad_t v);
        quad_t r;
        logic  dd, other;
        dd    = v.l1 ^ v.l2;
        other = v.l3 ^ dd;
        r.l0  = v.l0;
        r.l1  = v.l0 ? other : v.l1;
        r.l2  = v.l0 ? v.l1  : other;
        r.l3  = dd;
        return r;
    endfunction

    function automatic logic [COST_W0-1:0] cost_of(input gate_e g);
        case (g)
            G_CXOR:  return 4'd1;
            G_CSWAP: return 4'd5;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/rev_fwd_bank.sv
module rev_fwd_bank
    import rev_pkg::*;
(
    input  quad_t vin,
    output quad_t vres [NGATES]
);
    for (genvar g = 0; g < NGATES; g++) begin : g_gate
        if (g == int'(G_CXOR)) begin : g_cx
            assign vres[g] = cxor_map(vin);
        end else if (g == int'(G_CSWAP)) begin : g_cs
            assign vres[g] = cswap_map(vin);
        end else if (g == int'(G_TSG)) begin : g_ts
            assign vres[g] = tsg_fwd(vin);
        end else begin : g_sy
            assign vres[g] = sayem_fwd(vin);
        end
    end
endmodule

// File: rtl/rev_bwd_bank.sv
module rev_bwd_bank
    import rev_pkg::*;
(
    input  quad_t vin,
    output quad_t vres [NGATES]
);
    for (genvar g = 0; g < NGATES; g++) begin : g_gate
        if (g == int'(G_CXOR)) begin : g_cx
            assign vres[g] = cxor_map(vin);
        end else if (g == int'(G_CSWAP)) begin : g_cs
            assign vres[g] = cswap_map(vin);
        end else if (g == int'(G_TSG)) begin : g_ts
            assign vres[g] = tsg_bwd(vin);
        end else begin : g_sy
            assign vres[g] = sayem_bwd(vin);
        end
    end
endmodule

// File: rtl/rev_out_sel.sv
module rev_out_sel
    import rev_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int COST_W = 4
)(
    input  logic [SEL_W-1:0]  sel,
    input  logic              bwd,
    input  quad_t             fwd_res [NGATES],
    input  quad_t             bwd_res [NGATES],
    output quad_t             vout,
    output logic [COST_W-1:0] cost,
    output logic              bad
);
    localparam int MAXSEL = NGATES - 1;

    logic [GIDX_W-1:0] idx;
    logic              in_range;

    assign idx      = sel[GIDX_W-1:0];
    assign in_range = (int'(sel) <= MAXSEL);

    always_comb begin
        vout = '0;
        cost = '0;
        bad  = 1'b1;
        if (in_range) begin
            bad  = 1'b0;
            vout = bwd ? bwd_res[idx] : fwd_res[idx];
            cost = COST_W'(cost_of(gate_e'(idx)));
        end
    end
endmodule

// File: rtl/rev_gate_lib.sv
module rev_gate_lib
    import rev_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int COST_W = 4
)(
    input  logic [SEL_W-1:0]  gate_sel,
    input  logic              dir_bwd,
    input  logic [LANES-1:0]  din,
    output logic [LANES-1:0]  dout,
    output logic [COST_W-1:0] qcost,
    output logic              sel_bad
);
    quad_t vin;
    quad_t vout;
    quad_t fres [NGATES];
    quad_t bres [NGATES];

    assign vin  = quad_t'(din);
    assign dout = LANES'(vout);

    rev_fwd_bank u_fwd (.vin(vin), .vres(fres));
    rev_bwd_bank u_bwd (.vin(vin), .vres(bres));

    rev_out_sel #(.SEL_W(SEL_W), .COST_W(COST_W)) u_sel (
        .sel     (gate_sel),
        .bwd     (dir_bwd),
        .fwd_res (fres),
        .bwd_res (bres),
        .vout    (vout),
        .cost    (qcost),
        .bad     (sel_bad)
    );
endmodule

// File: rtl/rev_gate_lib_chk.sv
module rev_gate_lib_chk #(
    parameter int SEL_W  = 3,
    parameter int COST_W = 4
)(
    input logic [SEL_W-1:0]  gate_sel,
    input logic              dir_bwd,
    input logic [3:0]        din,
    input logic [3:0]        dout,
    input logic [COST_W-1:0] qcost,
    input logic              sel_bad
);
    always_comb begin
        if (!$isunknown({gate_sel, dir_bwd, din})) begin
            // R11
            invalid_zero_chk: assert (!sel_bad || (dout == 4'd0 && qcost == '0));
            // R11
            invalid_flag_chk: assert (sel_bad == (int'(gate_sel) > 3));
            // R2
            ctl_lane_keep_chk: assert (sel_bad || dout[0] == din[0]);
            // R2
            swap_ones_chk: assert (!(gate_sel == 1 && !sel_bad) ||
                                   ($countones(dout) == $countones(din)));
            // R1
            cxor_pass_chk: assert (!(gate_sel == 0) || dout[3:2] == din[3:2]);
            // R4
            sayem_d_chk: assert (!(gate_sel == 3 && !dir_bwd) ||
                                 ((dout[1] ^ dout[2]) == din[3]));
            // R6
            tsg_dback_chk: assert (!(gate_sel == 2 && dir_bwd) ||
                                   (dout[3] == (din[1] ^ din[2])));
            // R7
            sayem_dback_chk: assert (!(gate_sel == 3 && dir_bwd) ||
                                     (dout[3] == (din[1] ^ din[2])));
            // R10
            cost_cxor_chk: assert (!(gate_sel == 0) || qcost == COST_W'(1));
        end
    end
endmodule

bind rev_gate_lib rev_gate_lib_chk #(.SEL_W(SEL_W), .COST_W(COST_W)) u_chk (
    .gate_sel (gate_sel),
    .dir_bwd  (dir_bwd),
    .din      (din),
    .dout     (dout),
    .qcost    (qcost),
    .sel_bad  (sel_bad)
);

// File: tb/sim_rev_gate_lib.sv
module sim_rev_gate_lib;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] gate_sel = 3'd4;
    logic       dir_bwd = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] dout;
    logic [3:0] qcost;
    logic       sel_bad;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rev_gate_lib u0 (
        .gate_sel (gate_sel),
        .dir_bwd  (dir_bwd),
        .din      (din),
        .dout     (dout),
        .qcost    (qcost),
        .sel_bad  (sel_bad)
    );

    function automatic logic [3:0] model_fwd(input int g, input logic [3:0] x);
        logic a, b, c, d, q, r, s, m1, m2;
        a = x[0]; b = x[1]; c = x[2]; d = x[3];
        case (g)
            0: return {d, c, a ^ b, a};
            1: return a ? {d, b, c, a} : x;
            2: begin
                q = (~a & ~c) ^ ~b;
                r = q ^ d;
                s = (q & d) ^ (a & b) ^ c;
                return {s, r, q, a};
            end
            default: begin
                m1 = a ? c : b;
                m2 = a ? b : c;
                return {m2 ^ d, m1 ^ d, m1, a};
            end
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input int g, input bit bw, input logic [3:0] x);
        @(negedge clk);
        gate_sel = 3'(g);
        dir_bwd  = bw;
        din      = x;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] y;
        logic [3:0] z;
        logic [15:0] seen;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // initial state: invalid code 4 applied from time zero (R11)
        check("R11 init flag", int'(sel_bad), 1);
        check("R11 init data", int'(dout), 0);

        for (int g = 0; g < 4; g++) begin
            seen = '0;
            for (int x = 0; x < 16; x++) begin
                apply(g, 1'b0, 4'(x));
                y = dout;
                case (g)
                    0: check("R1 cxor fwd", int'(y), int'(model_fwd(g, 4'(x))));
                    1: check("R2 cswap fwd", int'(y), int'(model_fwd(g, 4'(x))));
                    2: check("R3 tsg fwd", int'(y), int'(model_fwd(g, 4'(x))));
                    default: check("R4 sayem fwd", int'(y), int'(model_fwd(g, 4'(x))));
                endcase
                check("R10 cost", int'(qcost), (g == 0) ? 1 : (g == 1) ? 5 : 0);
                check("R11 flag low", int'(sel_bad), 0);
                seen[y] = 1'b1;
                apply(g, 1'b1, y);
                case (g)
                    0, 1: check("R5 self inverse", int'(dout), x);
                    2: check("R6 tsg inverse", int'(dout), x);
                    default: check("R7 sayem inverse", int'(dout), x);
                endcase
                if (g < 2) begin
                    apply(g, 1'b1, 4'(x));
                    check("R5 bwd equals fwd", int'(dout), int'(model_fwd(g, 4'(x))));
                end
                apply(g, 1'b1, 4'(x));
                z = dout;
                apply(g, 1'b0, z);
                check("R9 fwd of bwd", int'(dout), x);
            end
            check("R8 distinct outputs", $countones(seen), 16);
        end

        for (int g = 4; g < 8; g++) begin
            for (int bw = 0; bw < 2; bw++) begin
                apply(g, bit'(bw), 4'hF);
                check("R11 bad flag", int'(sel_bad), 1);
                check("R11 zero data", int'(dout), 0);
                check("R11 zero cost", int'(qcost), 0);
                apply(g, bit'(bw), 4'h6);
                check("R11 zero data b", int'(dout), 0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule